// File: doc/BRIEF.md
# Bridge Secondary-Side Status Register

This block holds the 16-bit status word that describes the secondary bus of a bus-to-bus bridge. The secondary interface logic reports each error it sees as a single-cycle pulse. The block qualifies those pulses, captures them in sticky flags, and presents them with a handful of fixed capability bits. It is reached through a small configuration port at a single offset, which defaults to 1Eh.

Each flag has its own qualification rule. The detected-parity flag collects three kinds of uncorrectable parity or attribute error and ignores the parity-response enable. The master data-parity flag counts only when the bridge is bus master and that enable is set. Software clears flags by writing ones. Writes honour per-byte enables. A set event that lands in the same cycle as its clear leaves the flag set.

Reads are combinational from the held state. A write or a set event becomes visible on the read port after the next rising clock edge.

Top module: `sec_status_reg`

## Requirements
- R1: After reset, a read at the register offset returns 16'h02A0.
- R2: Bits 10:9 always read 01b, bit 7 reads 1 and bit 5 reads 1. Bit 6 and bits 4:0 read 0. Writes of any value leave all of these unchanged.
- R3: Bit 15 sets after an uncorrectable address or attribute error seen as potential target. It also sets after a data error seen as target of a write, or a data error seen as master of a read. The parity-response enable has no effect on it.
- R4: Bit 8 sets only when three conditions hold in the same cycle. The bridge must be bus master, the parity-response enable must be 1, and a PERR must either be driven on a read or be seen on a write. If any condition is missing, the bit stays 0.
- R5: Bit 14 sets on a system-error assertion, and bit 13 on a master abort issued as master. Bit 12 sets when a target abort is received, and bit 11 when a target abort is signalled as target.
- R6: Bits 15:11 and bit 8 are sticky. Once set, each holds until software clears it.
- R7: Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged. Byte lane 1 (cfg_be[1], bits 15:8) must be enabled for a clear. Lane 0 holds no clearable bit, and a write with only lane 0 enabled has no effect.
- R8: If a set event and a clear hit the same sticky bit in the same cycle, the bit ends at 1.
- R9: A read at any other address returns 0. A write at any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables, bit 1 = bits 15:8 |
| cfg_wdata | input | 16 | Write data, ones clear sticky bits |
| cfg_rdata | output | 16 | Read data, 0 when the address misses |
| perr_resp_en | input | 1 | Parity-response enable from the control register |
| bus_master | input | 1 | Bridge owns the current secondary transaction |
| ev_addr_perr_tgt | input | 1 | Address or attribute error as potential target |
| ev_data_perr_tgt_wr | input | 1 | Data error as target of a write |
| ev_data_perr_mst_rd | input | 1 | Data error as master of a read |
| ev_perr_drv_rd | input | 1 | Bridge drives PERR on a read |
| ev_perr_seen_wr | input | 1 | Bridge samples PERR on a write |
| ev_serr_seen | input | 1 | System-error assertion detected |
| ev_mabort | input | 1 | Master abort issued by the bridge |
| ev_tabort_rcvd | input | 1 | Target abort received |
| ev_tabort_sig | input | 1 | Target abort signalled by the bridge |

## Verification
A set event and a software clear can arrive in the same cycle. The bench drives an abort pulse and a write of ones to the same flag on the same clock edge, then reads the flag back and expects it to stay 1. It also pairs a clear of one flag with the set of a different flag in the same edge, and expects only the cleared flag to drop.

// File: rtl/sec_status_pkg.sv
package sec_status_pkg;
   localparam int SS_W  = 16;
   localparam int SS_BE = SS_W / 8;

   localparam int IDX_PAR_DET   = 15;
   localparam int IDX_SYS_ERR   = 14;
   localparam int IDX_MST_ABT   = 13;
   localparam int IDX_TGT_ABT_R = 12;
   localparam int IDX_TGT_ABT_S = 11;
   localparam int IDX_MST_PAR   = 8;

   localparam logic [SS_W-1:0] SS_STICKY_MASK = 16'hF900;
   localparam logic [SS_W-1:0] SS_RO_VALUE    = 16'h02A0;
endpackage

// File: rtl/ss_evt_qual.sv
module ss_evt_qual
   import sec_status_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            perr_resp_en,
   input  logic            bus_master,
   input  logic            ev_addr_perr_tgt,
   input  logic            ev_data_perr_tgt_wr,
   input  logic            ev_data_perr_mst_rd,
   input  logic            ev_perr_drv_rd,
   input  logic            ev_perr_seen_wr,
   input  logic            ev_serr_seen,
   input  logic            ev_mabort,
   input  logic            ev_tabort_rcvd,
   input  logic            ev_tabort_sig,
   output logic [SS_W-1:0] set_vec
);
   logic par_any;
   logic mpar_ok;

   assign par_any = ev_addr_perr_tgt | ev_data_perr_tgt_wr | ev_data_perr_mst_rd;
   assign mpar_ok = bus_master & perr_resp_en & (ev_perr_drv_rd | ev_perr_seen_wr);

   always_comb begin
      set_vec                = '0;
      set_vec[IDX_PAR_DET]   = par_any;
      set_vec[IDX_SYS_ERR]   = ev_serr_seen;
      set_vec[IDX_MST_ABT]   = ev_mabort;
      set_vec[IDX_TGT_ABT_R] = ev_tabort_rcvd;
      set_vec[IDX_TGT_ABT_S] = ev_tabort_sig;
      set_vec[IDX_MST_PAR]   = mpar_ok;
   end

   // R4: without the enable, no master parity request may leave this stage
   p_mpar_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_resp_en |-> !set_vec[IDX_MST_PAR]);
   // R3: each parity input alone requests the detected-parity flag
   p_par_det_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr_perr_tgt || ev_data_perr_tgt_wr || ev_data_perr_mst_rd) |-> set_vec[IDX_PAR_DET]);
endmodule

// File: rtl/ss_w1c_dec.sv
module ss_w1c_dec
   import sec_status_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int REG_OFFSET = 'h1E
)(
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [SS_BE-1:0]  cfg_be,
   input  logic [SS_W-1:0]   cfg_wdata,
   output logic              hit,
   output logic [SS_W-1:0]   clr_vec
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

   logic [SS_W-1:0] be_mask;

   for (genvar g = 0; g < SS_BE; g++) begin : g_lane
      assign be_mask[g*8 +: 8] = {8{cfg_be[g]}};
   end

   assign hit     = (cfg_addr == OFS);
   assign clr_vec = (cfg_wr && hit) ? (cfg_wdata & be_mask & SS_STICKY_MASK) : '0;
endmodule

// File: rtl/ss_sticky_cell.sv
module ss_sticky_cell #(
   parameter bit SET_WINS = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_nxt;

   if (SET_WINS) begin : g_set_pri
      assign q_nxt = set_i | (q_o & ~clr_i);
      // R8: a set in the same cycle as a clear leaves the flag at 1
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         set_i |=> q_o);
   end else begin : g_clr_pri
      assign q_nxt = (q_o | set_i) & ~clr_i;
      p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i |=> !q_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_nxt;
   end

   // R7: a clear without a set drops the flag
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R6: with no set and no clear the flag holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/sec_status_reg.sv
module sec_status_reg
   import sec_status_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int REG_OFFSET = 'h1E,
   parameter bit SET_WINS   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_be,
   input  logic [15:0]       cfg_wdata,
   output logic [15:0]       cfg_rdata,
   input  logic              perr_resp_en,
   input  logic              bus_master,
   input  logic              ev_addr_perr_tgt,
   input  logic              ev_data_perr_tgt_wr,
   input  logic              ev_data_perr_mst_rd,
   input  logic              ev_perr_drv_rd,
   input  logic              ev_perr_seen_wr,
   input  logic              ev_serr_seen,
   input  logic              ev_mabort,
   input  logic              ev_tabort_rcvd,
   input  logic              ev_tabort_sig
);
   if (ADDR_W < 2 || REG_OFFSET < 0 || REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("sec_status_reg: REG_OFFSET does not fit in ADDR_W");
   end
   if ((REG_OFFSET % SS_BE) != 0) begin : g_bad_align
      $error("sec_status_reg: REG_OFFSET must be aligned to the register width");
   end
   if (SS_BE != 2) begin : g_bad_width
      $error("sec_status_reg: port widths assume a 16-bit register");
   end

   logic [SS_W-1:0] set_vec;
   logic [SS_W-1:0] clr_vec;
   logic [SS_W-1:0] status;
   logic            hit;

   ss_evt_qual u_qual (
      .clk                 (clk),
      .rst_n               (rst_n),
      .perr_resp_en        (perr_resp_en),
      .bus_master          (bus_master),
      .ev_addr_perr_tgt    (ev_addr_perr_tgt),
      .ev_data_perr_tgt_wr (ev_data_perr_tgt_wr),
      .ev_data_perr_mst_rd (ev_data_perr_mst_rd),
      .ev_perr_drv_rd      (ev_perr_drv_rd),
      .ev_perr_seen_wr     (ev_perr_seen_wr),
      .ev_serr_seen        (ev_serr_seen),
      .ev_mabort           (ev_mabort),
      .ev_tabort_rcvd      (ev_tabort_rcvd),
      .ev_tabort_sig       (ev_tabort_sig),
      .set_vec             (set_vec)
   );

   ss_w1c_dec #(
      .ADDR_W     (ADDR_W),
      .REG_OFFSET (REG_OFFSET)
   ) u_dec (
      .cfg_addr  (cfg_addr),
      .cfg_wr    (cfg_wr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .hit       (hit),
      .clr_vec   (clr_vec)
   );

   for (genvar b = 0; b < SS_W; b++) begin : g_bit
      if (SS_STICKY_MASK[b]) begin : g_stk
         ss_sticky_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[b]),
            .clr_i (clr_vec[b]),
            .q_o   (status[b])
         );
      end else begin : g_ro
         logic unused_ro;
         assign unused_ro = set_vec[b] | clr_vec[b];
         assign status[b] = SS_RO_VALUE[b];
      end
   end

   assign cfg_rdata = hit ? status : '0;

   // R2: fixed fields hold their values whenever the register is selected
   p_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == ADDR_W'(REG_OFFSET)) |-> ((cfg_rdata & ~SS_STICKY_MASK) == SS_RO_VALUE));
   // R9: a miss reads zero
   p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr != ADDR_W'(REG_OFFSET)) |-> (cfg_rdata == '0));
   // R4: a clear master parity flag stays clear while the enable is off
   p_mpar_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!perr_resp_en && !status[IDX_MST_PAR]) |=> !status[IDX_MST_PAR]);
   // R3: any parity input raises bit 15 by the next edge
   p_par_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr_perr_tgt || ev_data_perr_tgt_wr || ev_data_perr_mst_rd) |=> status[IDX_PAR_DET]);
endmodule

// File: tb/sec_status_reg_tb.sv
`timescale 1ns/1ps
module sec_status_reg_tb;
   localparam logic [7:0]  OFS  = 8'h1E;
   localparam logic [15:0] BASE = 16'h02A0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = OFS;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_be = 2'b00;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        perr_resp_en = 1'b0;
   logic        bus_master = 1'b0;
   // 0 addr_tgt,1 data_tgt_wr,2 data_mst_rd,3 perr_drv_rd,4 perr_seen_wr,
   // 5 serr,6 mabort,7 tabort_rcvd,8 tabort_sig
   logic [8:0]  ev = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sec_status_reg u_dut (
      .clk                 (clk),
      .rst_n               (rst_n),
      .cfg_addr            (cfg_addr),
      .cfg_wr              (cfg_wr),
      .cfg_be              (cfg_be),
      .cfg_wdata           (cfg_wdata),
      .cfg_rdata           (cfg_rdata),
      .perr_resp_en        (perr_resp_en),
      .bus_master          (bus_master),
      .ev_addr_perr_tgt    (ev[0]),
      .ev_data_perr_tgt_wr (ev[1]),
      .ev_data_perr_mst_rd (ev[2]),
      .ev_perr_drv_rd      (ev[3]),
      .ev_perr_seen_wr     (ev[4]),
      .ev_serr_seen        (ev[5]),
      .ev_mabort           (ev[6]),
      .ev_tabort_rcvd      (ev[7]),
      .ev_tabort_sig       (ev[8])
   );

   task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      n_chk++;
      if (cfg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, cfg_rdata, exp);
      end
      cfg_addr = OFS;
   endtask

   task automatic fire(input logic [8:0] v, input logic mst, input logic en);
      @(negedge clk);
      ev = v; bus_master = mst; perr_resp_en = en;
      @(posedge clk); #1;
      ev = '0; bus_master = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk); #1;
      cfg_wr = 1'b0; cfg_addr = OFS;
   endtask

   task automatic fire_and_wr(input logic [8:0] v, input logic [15:0] d);
      @(negedge clk);
      ev = v; cfg_addr = OFS; cfg_be = 2'b11; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk); #1;
      ev = '0; cfg_wr = 1'b0;
   endtask

   task automatic t_reset_r1;
      rd_chk(OFS, BASE, "R1 reset value");
   endtask

   task automatic t_const_r2;
      wr(OFS, 2'b11, 16'hFFFF);
      rd_chk(OFS, BASE, "R2 fixed fields after all-ones write");
      wr(OFS, 2'b01, 16'h00FF);
      rd_chk(OFS, BASE, "R2 fixed fields after low-byte write");
   endtask

   task automatic t_par_det_r3;
      for (int i = 0; i < 3; i++) begin
         fire(9'(1 << i), 1'b0, 1'b0);
         rd_chk(OFS, BASE | 16'h8000, $sformatf("R3 parity source %0d with enable off", i));
         wr(OFS, 2'b10, 16'h8000);
         rd_chk(OFS, BASE, "R7 clear of bit 15");
      end
      fire(9'b000000001, 1'b1, 1'b1);
      rd_chk(OFS, BASE | 16'h8000, "R3 parity with enable on");
      wr(OFS, 2'b10, 16'h8000);
   endtask

   task automatic t_mst_par_r4;
      fire(9'b000001000, 1'b1, 1'b0);
      rd_chk(OFS, BASE, "R4 enable off blocks bit 8");
      fire(9'b000011000, 1'b0, 1'b1);
      rd_chk(OFS, BASE, "R4 not master blocks bit 8");
      fire(9'b000000000, 1'b1, 1'b1);
      rd_chk(OFS, BASE, "R4 no PERR leaves bit 8 clear");
      fire(9'b000001000, 1'b1, 1'b1);
      rd_chk(OFS, BASE | 16'h0100, "R4 PERR driven on read");
      wr(OFS, 2'b10, 16'h0100);
      rd_chk(OFS, BASE, "R4 bit 8 cleared");
      fire(9'b000010000, 1'b1, 1'b1);
      rd_chk(OFS, BASE | 16'h0100, "R4 PERR seen on write");
      wr(OFS, 2'b10, 16'h0100);
      perr_resp_en = 1'b0;
   endtask

   task automatic t_abort_r5;
      logic [15:0] bitv [4] = '{16'h4000, 16'h2000, 16'h1000, 16'h0800};
      for (int i = 0; i < 4; i++) begin
         fire(9'(1 << (5 + i)), 1'b0, 1'b0);
         rd_chk(OFS, BASE | bitv[i], $sformatf("R5 event %0d sets its flag", i));
         wr(OFS, 2'b10, bitv[i]);
      end
      rd_chk(OFS, BASE, "R5 all abort flags cleared");
   endtask

   task automatic t_sticky_r6;
      fire(9'b001000000, 1'b0, 1'b0);
      repeat (12) @(posedge clk);
      rd_chk(OFS, BASE | 16'h2000, "R6 flag held after idle cycles");
      wr(OFS, 2'b10, 16'h2000);
   endtask

   task automatic t_w1c_r7;
      fire(9'h1FF, 1'b1, 1'b1);
      perr_resp_en = 1'b0;
      rd_chk(OFS, 16'hFBA0, "R7 all sticky set");
      wr(OFS, 2'b11, 16'h0000);
      rd_chk(OFS, 16'hFBA0, "R7 zero write leaves flags");
      wr(OFS, 2'b01, 16'hFFFF);
      rd_chk(OFS, 16'hFBA0, "R7 lane 0 only leaves flags");
      wr(OFS, 2'b10, 16'h4000);
      rd_chk(OFS, 16'hBBA0, "R7 single bit clear");
      wr(OFS, 2'b11, 16'hFFFF);
      rd_chk(OFS, BASE, "R7 clear all");
   endtask

   task automatic t_collide_r8;
      fire_and_wr(9'b010000000, 16'h1000);
      rd_chk(OFS, BASE | 16'h1000, "R8 set beats clear same bit");
      fire_and_wr(9'b000100000, 16'h1000);
      rd_chk(OFS, BASE | 16'h4000, "R8 clear one bit while setting another");
      wr(OFS, 2'b10, 16'h4000);
   endtask

   task automatic t_miss_r9;
      fire(9'b100000000, 1'b0, 1'b0);
      rd_chk(8'h1C, 16'h0000, "R9 read miss returns zero");
      wr(8'h1C, 2'b11, 16'hFFFF);
      rd_chk(OFS, BASE | 16'h0800, "R9 write miss has no effect");
      wr(OFS, 2'b10, 16'h0800);
      rd_chk(OFS, BASE, "R9 cleared through the right offset");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_r1();
      t_const_r2();
      t_par_det_r3();
      t_mst_par_r4();
      t_abort_r5();
      t_sticky_r6();
      t_w1c_r7();
      t_collide_r8();
      t_miss_r9();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule